// File: doc/BRIEF.md
# Alarm and Indicator Mode Controller

This block watches a set of debounced digital inputs and turns them into alarm state. Whenever the sample strobe is high, each channel's input bit is compared with two per-channel programmable bits: a high threshold and a low threshold. An input of 1 against a high threshold of 0 raises that channel's high alarm. An input of 0 against a low threshold of 1 raises its low alarm. Alarm bits are sticky. A single clear command wipes all of them together.

Each alarm bit has a companion search flag. The flag records the moment the alarm went from inactive to active, and software clears flags one at a time by writing a mask. The OR of all flags forms a single device-level alarm line, which a bus front end can use to decide whether to answer an alarm-only enumeration.

Two indicator outputs, an LED and a relay driver, each take a 2-bit mode. The mode selects whether the indicator tracks the live alarm state, holds on from an alarm onset until the next clear command, follows a software state bit, or stays off. All outputs are registered. A strobe, clear or mode change shows at the outputs one clock after the edge that captures it.

Top module: `alarm_ind_ctrl`

## Requirements
- R1: When `sample_i` is high at a clock edge, bit i of `alm_hi_o` becomes 1 after that edge if `din_i[i]` is 1 and `hi_thr_i[i]` is 0.
- R2: When `sample_i` is high at a clock edge, bit i of `alm_lo_o` becomes 1 after that edge if `din_i[i]` is 0 and `lo_thr_i[i]` is 1.
- R3: With every high threshold bit at 1 and every low threshold bit at 0, no sample raises any alarm, whatever the input byte.
- R4: Alarm bits are sticky. Without `sample_i` they never change except through `clr_alarms_i`, which clears every high and low alarm bit at the next edge. No input clears a single alarm bit.
- R5: If `sample_i` raises an alarm bit in the same cycle that `clr_alarms_i` is high, that bit is 1 after the edge.
- R6: `srch_flag_o` bit i is the high-alarm onset flag of channel i, and bit NCH+i is the low-alarm onset flag of channel i. A flag sets only on the edge where its alarm bit goes from 0 to 1. A sample that finds the alarm already set does not set it. `clr_alarms_i` does not clear flags.
- R7: A 1 in bit k of `srch_clr_i` clears flag k at the next edge, and a 0 leaves it unchanged. If flag k's onset happens in the same cycle, the flag ends up set.
- R8: `dev_alarm_o` is 1 exactly when at least one bit of `srch_flag_o` is 1, in the same cycle.
- R9: Mode 2'b00: the indicator is on while any high or low alarm bit is 1 and off when none is.
- R10: Mode 2'b01: the indicator turns on at any alarm onset and stays on until a clear command. A clear command without a new onset in the same cycle turns it off, even if a re-sample keeps an alarm bit set.
- R11: Mode 2'b10: the indicator equals its manual state bit (`led_man_i` or `rly_man_i`). Mode 2'b11: the indicator is off.
- R12: While `rst` is high, and after it, until an alarm occurs or an indicator is driven on, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Strobe: compare the input byte in this cycle |
| din_i | input | NCH | Debounced input states |
| hi_thr_i | input | NCH | High alarm threshold bit per channel |
| lo_thr_i | input | NCH | Low alarm threshold bit per channel |
| clr_alarms_i | input | 1 | Clear-all-alarms command pulse |
| srch_clr_i | input | 2*NCH | Search flag clear mask, one bit per flag |
| led_mode_i | input | 2 | LED mode |
| rly_mode_i | input | 2 | Relay mode |
| led_man_i | input | 1 | LED manual state |
| rly_man_i | input | 1 | Relay manual state |
| alm_hi_o | output | NCH | Sticky high alarm bits |
| alm_lo_o | output | NCH | Sticky low alarm bits |
| srch_flag_o | output | 2*NCH | Onset flags, high alarms in the low half |
| dev_alarm_o | output | 1 | OR of all onset flags |
| led_o | output | 1 | LED drive |
| rly_o | output | 1 | Relay drive |

## Verification
A wrong alarm bit appears on `alm_hi_o` or `alm_lo_o` one edge after the strobe or clear that caused it, and it stays visible because the bits are sticky. A flag that sets on a re-sample instead of an onset shows up only after software has cleared it and the same input is sampled again, so the bench clears a flag and re-samples on purpose. A mix-up between the live and latched indicator modes is visible only when a clear and a re-sample land in the same cycle. The bench runs that exact cycle with one indicator in each mode.

// File: rtl/alarm_ind_pkg.sv
package alarm_ind_pkg;

  typedef enum logic [1:0] {
    IND_LIVE   = 2'b00,
    IND_LATCH  = 2'b01,
    IND_MANUAL = 2'b10,
    IND_OFF    = 2'b11
  } ind_mode_e;

endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] din_i,
  input  logic [NCH-1:0] hi_thr_i,
  input  logic [NCH-1:0] lo_thr_i,
  output logic [NCH-1:0] over_o,
  output logic [NCH-1:0] under_o
);

  // One comparator pair per channel: for single-bit values "above" means
  // input 1 with threshold 0, "below" means input 0 with threshold 1.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      over_o[g]  = din_i[g] & ~hi_thr_i[g];
      under_o[g] = ~din_i[g] & lo_thr_i[g];
    end
  end

endmodule

// File: rtl/alarm_bank.sv
module alarm_bank #(
  parameter int NCH = 8,
  localparam int NB = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_i,
  input  logic          clr_i,
  input  logic [NB-1:0] cond_i,
  input  logic [NB-1:0] srch_clr_i,
  output logic [NB-1:0] alm_o,
  output logic [NB-1:0] flag_o,
  output logic          dev_alarm_o,
  output logic          any_alm_d_o,
  output logic          onset_any_o
);

  logic [NB-1:0] alm_q, alm_d;
  logic [NB-1:0] flag_q, flag_d;
  logic [NB-1:0] onset;
  logic          dev_q;

  always_comb begin
    onset  = cond_i & {NB{sample_i}} & ~alm_q;
    alm_d  = (alm_q & {NB{~clr_i}}) | (cond_i & {NB{sample_i}});
    flag_d = (flag_q & ~srch_clr_i) | onset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q  <= '0;
      flag_q <= '0;
      dev_q  <= 1'b0;
    end else begin
      alm_q  <= alm_d;
      flag_q <= flag_d;
      dev_q  <= |flag_d;
    end
  end

  assign alm_o       = alm_q;
  assign flag_o      = flag_q;
  assign dev_alarm_o = dev_q;
  assign any_alm_d_o = |alm_d;
  assign onset_any_o = |onset;

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((alm_q & $past(alm_q)) == $past(alm_q)));

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !sample_i) |=> (alm_q == '0));

  // R6
  flag_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> ((flag_q & ~$past(flag_q)) == '0));

endmodule

// File: rtl/alarm_indicator.sv
module alarm_indicator
  import alarm_ind_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       man_i,
  input  logic       any_alm_d_i,
  input  logic       onset_any_i,
  input  logic       clr_i,
  output logic       ind_o
);

  logic latch_q, latch_d;
  logic ind_d;
  logic ind_q;
  ind_mode_e mode;

  always_comb begin
    mode    = ind_mode_e'(mode_i);
    latch_d = onset_any_i | (latch_q & ~clr_i);
    case (mode)
      IND_LIVE:   ind_d = any_alm_d_i;
      IND_LATCH:  ind_d = latch_d;
      IND_MANUAL: ind_d = man_i;
      default:    ind_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      ind_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      ind_q   <= ind_d;
    end
  end

  assign ind_o = ind_q;

  // R11
  forced_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11) |=> !ind_o);

  // R11
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10) |=> (ind_o == $past(man_i)));

endmodule

// File: rtl/alarm_ind_ctrl.sv
module alarm_ind_ctrl #(
  parameter int NCH = 8,
  localparam int NB = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample_i,
  input  logic [NCH-1:0] din_i,
  input  logic [NCH-1:0] hi_thr_i,
  input  logic [NCH-1:0] lo_thr_i,
  input  logic           clr_alarms_i,
  input  logic [NB-1:0]  srch_clr_i,
  input  logic [1:0]     led_mode_i,
  input  logic [1:0]     rly_mode_i,
  input  logic           led_man_i,
  input  logic           rly_man_i,
  output logic [NCH-1:0] alm_hi_o,
  output logic [NCH-1:0] alm_lo_o,
  output logic [NB-1:0]  srch_flag_o,
  output logic           dev_alarm_o,
  output logic           led_o,
  output logic           rly_o
);

  logic [NCH-1:0] over, under;
  logic [NB-1:0]  alm;
  logic           any_alm_d, onset_any;

  alarm_cmp #(.NCH(NCH)) cmp_i (
    .din_i    (din_i),
    .hi_thr_i (hi_thr_i),
    .lo_thr_i (lo_thr_i),
    .over_o   (over),
    .under_o  (under)
  );

  alarm_bank #(.NCH(NCH)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .sample_i    (sample_i),
    .clr_i       (clr_alarms_i),
    .cond_i      ({under, over}),
    .srch_clr_i  (srch_clr_i),
    .alm_o       (alm),
    .flag_o      (srch_flag_o),
    .dev_alarm_o (dev_alarm_o),
    .any_alm_d_o (any_alm_d),
    .onset_any_o (onset_any)
  );

  alarm_indicator led_ind_i (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (led_mode_i),
    .man_i       (led_man_i),
    .any_alm_d_i (any_alm_d),
    .onset_any_i (onset_any),
    .clr_i       (clr_alarms_i),
    .ind_o       (led_o)
  );

  alarm_indicator rly_ind_i (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (rly_mode_i),
    .man_i       (rly_man_i),
    .any_alm_d_i (any_alm_d),
    .onset_any_i (onset_any),
    .clr_i       (clr_alarms_i),
    .ind_o       (rly_o)
  );

  assign alm_hi_o = alm[NCH-1:0];
  assign alm_lo_o = alm[NB-1:NCH];

  // R8
  dev_alarm_or_chk: assert property (@(posedge clk) disable iff (rst)
    dev_alarm_o == (|srch_flag_o));

  // R9
  live_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (led_mode_i == 2'b00) |=> (led_o == (|{alm_hi_o, alm_lo_o})));

endmodule

// File: tb/alarm_ind_ctrl_tb_top.sv
module alarm_ind_ctrl_tb_top;

  localparam int NCH = 8;
  localparam int NB  = 2 * NCH;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sample_i = 1'b0;
  logic [NCH-1:0] din_i = '0;
  logic [NCH-1:0] hi_thr_i = '1;
  logic [NCH-1:0] lo_thr_i = '0;
  logic           clr_alarms_i = 1'b0;
  logic [NB-1:0]  srch_clr_i = '0;
  logic [1:0]     led_mode_i = 2'b11;
  logic [1:0]     rly_mode_i = 2'b11;
  logic           led_man_i = 1'b0;
  logic           rly_man_i = 1'b0;
  logic [NCH-1:0] alm_hi_o, alm_lo_o;
  logic [NB-1:0]  srch_flag_o;
  logic           dev_alarm_o, led_o, rly_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  alarm_ind_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .sample_i(sample_i), .din_i(din_i),
    .hi_thr_i(hi_thr_i), .lo_thr_i(lo_thr_i), .clr_alarms_i(clr_alarms_i),
    .srch_clr_i(srch_clr_i), .led_mode_i(led_mode_i), .rly_mode_i(rly_mode_i),
    .led_man_i(led_man_i), .rly_man_i(rly_man_i), .alm_hi_o(alm_hi_o),
    .alm_lo_o(alm_lo_o), .srch_flag_o(srch_flag_o), .dev_alarm_o(dev_alarm_o),
    .led_o(led_o), .rly_o(rly_o)
  );

  // Row: din, hi, lo, sample, clr, exp_hi, exp_lo, exp_flags (58 bits)
  localparam int NV = 7;
  localparam logic [57:0] VEC [NV] = '{
    {8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000}, // R3
    {8'h0F, 8'hF0, 8'h00, 1'b1, 1'b0, 8'h0F, 8'h00, 16'h000F}, // R1 R6
    {8'h00, 8'hFF, 8'h3C, 1'b1, 1'b0, 8'h0F, 8'h3C, 16'h3C0F}, // R2 R6
    {8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 16'h3C0F}, // R4 R6
    {8'hA5, 8'h00, 8'hFF, 1'b1, 1'b1, 8'hA5, 8'h5A, 16'h7EAF}, // R5
    {8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0, 8'hA5, 8'h5A, 16'h7EAF}, // R4
    {8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 16'h7EAF}  // R4
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    sample_i = 1'b0; clr_alarms_i = 1'b0; srch_clr_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R12 reset state
    chk("R12 alm_hi", 32'(alm_hi_o), 0);
    chk("R12 alm_lo", 32'(alm_lo_o), 0);
    chk("R12 flags", 32'(srch_flag_o), 0);
    chk("R12 ind", {30'd0, led_o, rly_o}, 0);
    rst = 1'b0;
    step();
    chk("R12 after reset dev", 32'(dev_alarm_o), 0);

    for (int v = 0; v < NV; v++) begin
      din_i = VEC[v][57:50]; hi_thr_i = VEC[v][49:42]; lo_thr_i = VEC[v][41:34];
      sample_i = VEC[v][33]; clr_alarms_i = VEC[v][32];
      step();
      idle();
      chk("R1/R3/R4/R5 hi row", 32'(alm_hi_o), 32'(VEC[v][31:24]));
      chk("R2/R3/R4/R5 lo row", 32'(alm_lo_o), 32'(VEC[v][23:16]));
      chk("R6 flags row", 32'(srch_flag_o), 32'(VEC[v][15:0]));
      chk("R8 dev row", 32'(dev_alarm_o), 32'(VEC[v][15:0] != 0));
    end

    // R7 clear by mask
    srch_clr_i = 16'h000F; step(); idle();
    chk("R7 mask clear", 32'(srch_flag_o), 32'h7EA0);

    // R7 onset wins over clear in same cycle
    din_i = 8'h01; hi_thr_i = 8'h00; lo_thr_i = 8'h00;
    sample_i = 1'b1; srch_clr_i = 16'h0001; step(); idle();
    chk("R7 onset wins", 32'(srch_flag_o), 32'h7EA1);

    // R6 re-sample of a set alarm does not re-set the flag
    srch_clr_i = 16'h0001; step(); idle();
    sample_i = 1'b1; step(); idle();
    chk("R6 no re-onset", 32'(srch_flag_o), 32'h7EA0);

    // R8 all flags cleared
    srch_clr_i = '1; step(); idle();
    chk("R8 dev low", 32'(dev_alarm_o), 0);
    chk("R4 alarm survives flag clear", 32'(alm_hi_o), 32'h01);

    // R9 / R10 with hi0 alarm active and latch set by its onset
    led_mode_i = 2'b00; rly_mode_i = 2'b01; step();
    chk("R9 live on", 32'(led_o), 1);
    chk("R10 latch on", 32'(rly_o), 1);

    // clear + re-sample same cycle: alarm stays, latch drops
    clr_alarms_i = 1'b1; sample_i = 1'b1; step(); idle();
    chk("R5 alarm kept", 32'(alm_hi_o), 32'h01);
    chk("R9 live stays", 32'(led_o), 1);
    chk("R10 latch cleared", 32'(rly_o), 0);
    chk("R8 dev no onset", 32'(dev_alarm_o), 0);

    // R11 manual and off
    led_mode_i = 2'b10; led_man_i = 1'b0; step();
    chk("R11 manual 0", 32'(led_o), 0);
    led_man_i = 1'b1; step();
    chk("R11 manual 1", 32'(led_o), 1);
    led_mode_i = 2'b11; rly_mode_i = 2'b11; step();
    chk("R11 off led", 32'(led_o), 0);
    chk("R11 off rly", 32'(rly_o), 0);

    // R9 clear alone drops live indicator
    led_mode_i = 2'b00; clr_alarms_i = 1'b1; step(); idle();
    chk("R4 cleared", 32'(alm_hi_o), 0);
    chk("R9 live off", 32'(led_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule